// File: doc/BRIEF.md
# Atomic-Alias Register Bank

This block is a small register file for a peripheral. Each register is one data word and owns a 16-byte address slot. Software reaches the register through four word addresses inside that slot. One address replaces the value. The other three are write-only bit-operation views: one sets bits, one clears bits and one inverts bits, in each case only the bits marked by ones in the write data. Software can therefore change single bits with one bus write and no read-modify-write.

The bus side is a plain synchronous slave. It has a write strobe, a read strobe, a byte address and write data, and it returns registered read data and an error flag. The register contents also leave the block as one flat parallel vector, which feeds the peripheral logic that the registers control.

Per-register parameters set three things: the reset value, whether the three bit-operation views exist at all, and a protect mask. A protect mask bit marks a bit that a plain write cannot change. Such a bit can only be changed through the set and clear views.

Top module: `alias_regbank`

## Requirements
- R1: Synchronous active-high reset loads every register with its own `RESET_VALS` word. Register i is bits `[i*DATA_W +: DATA_W]` of that parameter.
- R2: A write to slot offset 0x0 (address bits [3:2] = 0) loads the write data into every bit that is not protected. The new value appears on `regs_o` after that clock edge.
- R3: Bits set in the register's `PROT_MASK` word keep their value through plain writes and toggle writes.
- R4: A write to offset 0x4 (bits [3:2] = 1) forces to one every bit that is one in the write data, including protected bits. All other bits are unchanged.
- R5: A write to offset 0x8 (bits [3:2] = 2) forces to zero every bit that is one in the write data, including protected bits. All other bits are unchanged.
- R6: A write to offset 0xC (bits [3:2] = 3) inverts every unprotected bit that is one in the write data.
- R7: A read at any of the four offsets of a slot returns the current register value on `rd_data` one cycle after the read strobe.
- R8: For a register whose `ALIAS_EN` bit is 0, any access to offsets 0x4, 0x8 or 0xC is rejected. The register keeps its value, `bus_err` rises and `rd_data` returns zero.
- R9: An access whose address bits [1:0] are not zero, or whose slot number (address bits above bit 3) is at or above `NUM_REGS`, raises `bus_err` in the next cycle. It changes no register, and a read of that kind returns zero.
- R10: `bus_err` is high for exactly the one cycle that follows each rejected access. After a valid access or an idle cycle it is low.
- R11: When the read and write strobes are both high for the same register in one cycle, `rd_data` returns the value from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address: slot number above bit 3, view in [3:2] |
| wdata | input | DATA_W | Write data or bit-operation mask |
| rd_data | output | DATA_W | Registered read data, zero after a rejected or absent read |
| bus_err | output | 1 | One-cycle flag for a rejected access |
| regs_o | output | NUM_REGS*DATA_W | All register values, register i at `[i*DATA_W +: DATA_W]` |

## Verification
Two things can happen in the same clock edge: a bus read is captured while a write, which may be a bit-operation write, updates the same register. The bench provokes this by raising both strobes in one cycle, first with directed masks and then across the random sequence. The expected result is the model's pre-write value on `rd_data` and the post-write value on `regs_o`, both taken from the following sample point. A rejected access can also carry a read strobe. In that case the bench expects zero read data together with the error flag.

// File: rtl/alias_regbank_pkg.sv
package alias_regbank_pkg;
   // Word view selected by address bits [3:2] inside a 16-byte slot
   typedef enum logic [1:0] {
      VW_PLAIN = 2'd0,
      VW_SET   = 2'd1,
      VW_CLR   = 2'd2,
      VW_TOG   = 2'd3
   } view_e;

   localparam int SLOT_LSB = 4;   // slot number starts above the 16-byte slot
endpackage

// File: rtl/arb_addr_decode.sv
module arb_addr_decode
   import alias_regbank_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NUM_REGS   = 4,
   parameter int IDX_W      = 2,
   parameter logic [NUM_REGS-1:0] ALIAS_EN = '1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              ok,
   output logic [IDX_W-1:0]  idx,
   output view_e             view
);
   localparam int SLOT_W = ADDR_W - SLOT_LSB;

   logic [SLOT_W-1:0] slot;
   logic              aligned;

   assign slot    = addr[ADDR_W-1:SLOT_LSB];
   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      view = view_e'(addr[3:2]);
      idx  = '0;
      ok   = 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(slot) == i) begin
            idx = IDX_W'(i);
            ok  = aligned && ((view == VW_PLAIN) || ALIAS_EN[i]);
         end
      end
   end
endmodule

// File: rtl/arb_reg_cell.sv
module arb_reg_cell
   import alias_regbank_pkg::*;
#(
   parameter int               DATA_W    = 32,
   parameter logic [DATA_W-1:0] RST_VAL  = '0,
   parameter logic [DATA_W-1:0] PROT     = '0,
   parameter bit               HAS_ALIAS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  view_e             op,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] nxt;
   logic [DATA_W-1:0] plain_val;

   assign plain_val = (q & PROT) | (wdata & ~PROT);

   generate
      if (HAS_ALIAS) begin : g_full
         always_comb begin
            nxt = q;
            if (wr_stb) begin
               unique case (op)
                  VW_PLAIN: nxt = plain_val;
                  VW_SET:   nxt = q | wdata;
                  VW_CLR:   nxt = q & ~wdata;
                  VW_TOG:   nxt = q ^ (wdata & ~PROT);
               endcase
            end
         end
      end else begin : g_plain
         always_comb begin
            nxt = q;
            if (wr_stb && (op == VW_PLAIN)) nxt = plain_val;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= nxt;
   end

   // R2: unprotected bits follow a plain write
   p_plain_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && op == VW_PLAIN) |=> ((q ^ $past(wdata)) & ~PROT) == '0);

   // R3: protected bits survive plain and toggle writes
   p_prot_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && (op == VW_PLAIN || op == VW_TOG)) |=> ((q ^ $past(q)) & PROT) == '0);

   // R8: no strobe, no change
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !wr_stb |=> $stable(q));

   generate
      if (HAS_ALIAS) begin : g_alias_chk
         p_set_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_stb && op == VW_SET) |=> ((q & $past(wdata)) == $past(wdata))
               && (((q ^ $past(q)) & ~$past(wdata)) == '0));
         p_clr_r5: assert property (@(posedge clk) disable iff (rst)
            (wr_stb && op == VW_CLR) |=> ((q & $past(wdata)) == '0)
               && (((q ^ $past(q)) & ~$past(wdata)) == '0));
         p_tog_r6: assert property (@(posedge clk) disable iff (rst)
            (wr_stb && op == VW_TOG) |=> (q ^ $past(q)) == ($past(wdata) & ~PROT));
      end
   endgenerate
endmodule

// File: rtl/arb_read_port.sv
module arb_read_port #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 4,
   parameter int IDX_W    = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       rd_en,
   input  logic                       wr_en,
   input  logic                       ok,
   input  logic [IDX_W-1:0]           idx,
   input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       bus_err
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (int'(idx) == i) sel = regs_flat[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data <= '0;
         bus_err <= 1'b0;
      end else begin
         rd_data <= (rd_en && ok) ? sel : '0;
         bus_err <= (rd_en || wr_en) && !ok;
      end
   end
endmodule

// File: rtl/alias_regbank.sv
module alias_regbank
   import alias_regbank_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 4,
   parameter int ADDR_W   = 8,
   parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS =
      {32'hA5A5_0000, 32'h0000_0000, 32'h1234_5678, 32'h0000_00FF},
   parameter logic [NUM_REGS-1:0] ALIAS_EN = 4'b1011,
   parameter logic [NUM_REGS*DATA_W-1:0] PROT_MASK =
      {32'hF000_0000, 32'h0000_0000, 32'h0000_FF00, 32'h0000_0000}
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic                       rd_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       bus_err,
   output logic [NUM_REGS*DATA_W-1:0] regs_o
);
   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("alias_regbank: DATA_W must be positive");
      end
      if (ADDR_W <= SLOT_LSB) begin : g_bad_addr
         $error("alias_regbank: ADDR_W must exceed the slot offset bits");
      end else if (NUM_REGS < 1 || NUM_REGS > (1 << (ADDR_W - SLOT_LSB))) begin : g_bad_count
         $error("alias_regbank: NUM_REGS does not fit the address space");
      end
   endgenerate

   logic             dec_ok;
   logic [IDX_W-1:0] dec_idx;
   view_e            dec_view;

   arb_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ALIAS_EN(ALIAS_EN)
   ) u_decode (
      .addr(addr), .ok(dec_ok), .idx(dec_idx), .view(dec_view)
   );

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
         logic stb;
         assign stb = wr_en && dec_ok && (int'(dec_idx) == g);
         arb_reg_cell #(
            .DATA_W   (DATA_W),
            .RST_VAL  (RESET_VALS[g*DATA_W +: DATA_W]),
            .PROT     (PROT_MASK[g*DATA_W +: DATA_W]),
            .HAS_ALIAS(ALIAS_EN[g])
         ) u_cell (
            .clk(clk), .rst(rst), .wr_stb(stb), .op(dec_view),
            .wdata(wdata), .q(regs_o[g*DATA_W +: DATA_W])
         );
      end
   endgenerate

   arb_read_port #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
   ) u_rdport (
      .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .ok(dec_ok),
      .idx(dec_idx), .regs_flat(regs_o), .rd_data(rd_data), .bus_err(bus_err)
   );

   // R9: a rejected access flags an error in the next cycle
   p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      ((wr_en || rd_en) && !dec_ok) |=> bus_err);

   // R10: no rejected access, no error in the next cycle
   p_err_single_r10: assert property (@(posedge clk) disable iff (rst)
      !((wr_en || rd_en) && !dec_ok) |=> !bus_err);

   // R8: a rejected access leaves every register as it was
   p_bad_still_r8: assert property (@(posedge clk) disable iff (rst)
      ((wr_en || rd_en) && !dec_ok) |=> $stable(regs_o));

   // R7: an accepted read returns the selected register as it was at the strobe
   p_rd_view_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && dec_ok) |=>
         rd_data == DATA_W'($past(regs_o) >> (DATA_W * int'($past(dec_idx)))));
endmodule

// File: tb/alias_regbank_tb.sv
module alias_regbank_tb;
   localparam int DW = 32;
   localparam int NR = 4;
   localparam int AW = 8;
   localparam logic [NR*DW-1:0] RV =
      {32'hA5A5_0000, 32'h0000_0000, 32'h1234_5678, 32'h0000_00FF};
   localparam logic [NR-1:0] AE = 4'b1011;
   localparam logic [NR*DW-1:0] PM =
      {32'hF000_0000, 32'h0000_0000, 32'h0000_FF00, 32'h0000_0000};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rd_data;
   logic bus_err;
   logic [NR*DW-1:0] regs_o;

   always #4 clk = ~clk;   // 125 MHz

   alias_regbank #(
      .DATA_W(DW), .NUM_REGS(NR), .ADDR_W(AW),
      .RESET_VALS(RV), .ALIAS_EN(AE), .PROT_MASK(PM)
   ) u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rd_data(rd_data), .bus_err(bus_err), .regs_o(regs_o)
   );

   typedef struct {
      bit               chk_rd;
      logic [DW-1:0]    rd;
      logic             err;
      logic [NR*DW-1:0] regs;
      string            tag;
   } item_t;

   item_t exp_q[$];
   logic [DW-1:0] model [NR];
   int checks = 0;
   int failures = 0;
   logic tb_issue = 1'b0;
   logic issue_seen;

   function automatic logic [NR*DW-1:0] pack_model();
      logic [NR*DW-1:0] v;
      for (int i = 0; i < NR; i++) v[i*DW +: DW] = model[i];
      return v;
   endfunction

   // Driver: compute the expectation from the requirements, queue it, drive the bus
   task automatic access(input logic we, input logic re, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input string tag);
      item_t it;
      int slot;
      int vw;
      logic bad;
      logic [DW-1:0] pm;
      slot = int'(a[AW-1:4]);
      vw   = int'(a[3:2]);
      bad  = (a[1:0] != 2'b00) || (slot >= NR);
      if (!bad && vw != 0 && !AE[slot]) bad = 1'b1;
      it.chk_rd = re;
      it.err    = (we || re) && bad;
      it.rd     = (re && !bad) ? model[slot] : '0;
      if (we && !bad) begin
         pm = PM[slot*DW +: DW];
         case (vw)
            0: model[slot] = (model[slot] & pm) | (d & ~pm);
            1: model[slot] = model[slot] | d;
            2: model[slot] = model[slot] & ~d;
            default: model[slot] = model[slot] ^ (d & ~pm);
         endcase
      end
      it.regs = pack_model();
      it.tag  = tag;
      exp_q.push_back(it);
      @(negedge clk);
      wr_en = we; rd_en = re; addr = a; wdata = d; tb_issue = 1'b1;
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0; tb_issue = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      access(1'b1, 1'b0, a, d, tag);
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      access(1'b0, 1'b1, a, '0, tag);
   endtask

   // Monitor: pop one expectation per issued cycle and compare after the edge
   always @(posedge clk) begin
      item_t it;
      issue_seen = tb_issue;
      #2;
      if (issue_seen) begin
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL monitor: result with no expectation queued");
         end else begin
            it = exp_q.pop_front();
            if (it.chk_rd) begin
               checks++;
               if (rd_data !== it.rd) begin
                  failures++;
                  $display("FAIL %s rd_data: actual %h expected %h", it.tag, rd_data, it.rd);
               end
            end
            checks++;
            if (bus_err !== it.err) begin
               failures++;
               $display("FAIL %s bus_err: actual %b expected %b", it.tag, bus_err, it.err);
            end
            checks++;
            if (regs_o !== it.regs) begin
               failures++;
               $display("FAIL %s regs_o: actual %h expected %h", it.tag, regs_o, it.regs);
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) model[i] = RV[i*DW +: DW];
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R1: reset values on regs_o and through reads
      for (int i = 0; i < NR; i++) rd(AW'(i * 16), "R1");

      // R2 / R3: plain writes, protected bits kept
      wr(8'h00, 32'hDEAD_BEEF, "R2");
      wr(8'h10, 32'h0000_0000, "R3");
      wr(8'h30, 32'h0123_4567, "R3");
      rd(8'h10, "R3");

      // R4 / R5: set and clear reach protected bits
      wr(8'h14, 32'h0000_0F00, "R4");
      wr(8'h18, 32'h0000_3000, "R5");
      wr(8'h34, 32'h0000_00F0, "R4");
      wr(8'h38, 32'hC000_0001, "R5");

      // R6: toggle skips protected bits
      wr(8'h0C, 32'hFFFF_0000, "R6");
      wr(8'h1C, 32'hFFFF_FFFF, "R6");

      // R7: every view reads back the register
      for (int v = 0; v < 4; v++) rd(AW'(16 + v * 4), "R7");

      // R8: register without alias views
      wr(8'h20, 32'h5555_AAAA, "R8");
      wr(8'h24, 32'hFFFF_FFFF, "R8");
      access(1'b0, 1'b1, 8'h28, '0, "R8");
      wr(8'h2C, 32'hFFFF_FFFF, "R8");
      rd(8'h20, "R8");

      // R9 / R10: misaligned and unimplemented accesses, single-cycle flag
      wr(8'h01, 32'h1111_1111, "R9");
      access(1'b0, 1'b1, 8'h12, '0, "R9");
      wr(8'h40, 32'h2222_2222, "R9");
      access(1'b0, 1'b0, 8'h00, '0, "R10");
      rd(8'hF0, "R9");
      rd(8'h00, "R10");

      // R11: read and write together on one register
      access(1'b1, 1'b1, 8'h00, 32'h0F0F_0F0F, "R11");
      access(1'b1, 1'b1, 8'h14, 32'h0000_FFFF, "R11");
      access(1'b1, 1'b1, 8'h3C, 32'hFFFF_FFFF, "R11");

      // Random mixture across all views, read back after each write
      for (int n = 0; n < 400; n++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         d = $urandom;
         a = AW'(($urandom % 5) * 16 + ($urandom % 4) * 4);
         if (($urandom % 16) == 0) a[1:0] = 2'($urandom % 4);
         access(1'b1, ($urandom % 4) == 0, a, d, "R11");
         rd(AW'((a >> 4) * 16 + ($urandom % 4) * 4), "R7");
      end

      access(1'b0, 1'b0, 8'h00, '0, "R10");
      while (exp_q.size() != 0) @(posedge clk);
      repeat (2) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule